// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Unit

This block joins two 8-input priority interrupt controllers, one as master and one as slave, so that a CPU can serve 16 request lines through a single interrupt pin. The slave's interrupt output is the only source for master input 2. Each chip keeps a request register, an in-service register and a rotation offset. It picks the highest-priority unmasked request and raises the CPU interrupt when that request outranks everything already in service.

When the CPU pulses `ack`, the master commits its winning line. If that line is the cascade input, the slave commits its own winner in the same cycle. One cycle later the block presents an 8-bit vector with a one-cycle valid pulse. Each line can be edge or level sensitive, set by two trigger-control bytes that are written and read through a small byte port. Some bits of those bytes are fixed by the block. Vector bases, masks and end-of-interrupt modes come in as plain inputs from the command decoder, which lives outside this block.

Top module: `casc_irq_ack`

## Requirements
- R1: External request `irq_in[2]` has no effect. Master input 2 is high exactly while the slave's interrupt output is high.
- R2: When a line is acknowledged, its request bit is cleared if the line is edge sensitive (trigger bit 0). The bit is kept if the line is level sensitive (trigger bit 1). A level request follows the input level, so it drops when the input drops.
- R3: Without auto-EOI, an acknowledge sets that line's in-service bit. A set in-service bit holds off requests of equal or lower priority, and a higher-priority request still raises `cpu_int`.
- R4: The priority order starts at the chip's rotation offset. Line (offset+k) mod 8 has rank k, and rank 0 is the highest. The offset resets to 0. An acknowledge with auto-EOI and rotate-on-auto-EOI both set changes the offset to (line+1) mod 8.
- R5: When the master acknowledges input 2, the slave is acknowledged in the same cycle. The reported line is the slave line plus 8.
- R6: One cycle after an accepted `ack`, `vec_vld` pulses for one cycle. `vec` is {base, line[2:0]}, where base is `mst_base` for lines 0–7 and `slv_base` for lines 8–15.
- R7: A write to the master trigger byte (`trig_sel`=0) stores the data ANDed with 0xF8, with bit 2 forced to 1. A read returns the stored value ANDed with 0xF8.
- R8: A write to the slave trigger byte (`trig_sel`=1) stores the data ANDed with 0xDE. A read returns the stored value ANDed with 0xDE.
- R9: After reset the master trigger byte is 0x04, and every other register is 0. `cpu_int`, `vec` and `vec_vld` are low, and both trigger reads return 0x00.
- R10: An `ack` while `cpu_int` is low leaves `vec_vld` low and changes no state.
- R11: A line whose mask bit is 1 (`mst_mask`/`slv_mask`, bit n for line n of that chip) cannot raise `cpu_int`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Request lines 0–15 (bit 2 ignored) |
| ack | input | 1 | CPU acknowledge strobe, one cycle |
| trig_we | input | 1 | Trigger byte write enable |
| trig_sel | input | 1 | 0 selects master byte, 1 selects slave byte |
| trig_wdata | input | 8 | Trigger byte write data |
| trig_rdata | output | 8 | Selected trigger byte, read mask applied |
| mst_base | input | 5 | Upper vector bits for lines 0–7 |
| slv_base | input | 5 | Upper vector bits for lines 8–15 |
| mst_mask | input | 8 | Master line masks |
| slv_mask | input | 8 | Slave line masks |
| aeoi | input | 1 | Auto-EOI mode, both chips |
| rot_aeoi | input | 1 | Rotate on auto-EOI, both chips |
| cpu_int | output | 1 | Interrupt request to the CPU |
| vec | output | 8 | Vector of the acknowledged line |
| vec_vld | output | 1 | One-cycle valid pulse for `vec` |

## Verification
The bench builds the block with its default parameters: master keep mask 0xF8, slave keep mask 0xDE and cascade input 2. Under those values, master lines 0 and 1 are always edge sensitive and slave lines 0 and 5 can never be made level sensitive. This makes the forced-bit reads, the acknowledge of an edge line and the repeated acknowledge of a level line on the slave (line 9) all reachable. The cascade input position sets which acknowledge passes through to the slave, and the bench exercises that pass-through together with rotation that reorders master lines 1, 3 and 6.

// File: rtl/casc_irq_ack.sv
module casc_irq_ack #(
  parameter logic [7:0] MST_KEEP = 8'hF8,
  parameter logic [7:0] SLV_KEEP = 8'hDE,
  parameter int         CAS_LINE = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_in,
  input  logic        ack,
  input  logic        trig_we,
  input  logic        trig_sel,
  input  logic [7:0]  trig_wdata,
  output logic [7:0]  trig_rdata,
  input  logic [4:0]  mst_base,
  input  logic [4:0]  slv_base,
  input  logic [7:0]  mst_mask,
  input  logic [7:0]  slv_mask,
  input  logic        aeoi,
  input  logic        rot_aeoi,
  output logic        cpu_int,
  output logic [7:0]  vec,
  output logic        vec_vld
);
  localparam logic [7:0] CAS_BIT = 8'(1) << CAS_LINE;
  localparam logic [2:0] CAS_IDX = 3'(CAS_LINE);

  function automatic logic [3:0] rank_of(input logic [7:0] m, input logic [2:0] r);
    logic [15:0] d;
    rank_of = 4'd8;
    d = {m, m} >> r;
    for (int i = 7; i >= 0; i--)
      if (d[i]) rank_of = 4'(i);
  endfunction

  logic [7:0] m_irr, m_isr, m_trg, m_prev;
  logic [7:0] s_irr, s_isr, s_trg, s_prev;
  logic [2:0] m_rot, s_rot;

  logic [7:0] m_in, s_in, m_req;
  logic [3:0] m_p, m_cur, s_p, s_cur;
  logic [2:0] m_ln, s_ln;
  logic       s_int, m_take, s_take;
  logic [7:0] m_bit, s_bit, m_clr, s_clr, m_rise, s_rise;

  assign m_in  = irq_in[7:0] & ~CAS_BIT;
  assign s_in  = irq_in[15:8];
  assign m_rise = m_in & ~m_prev;
  assign s_rise = s_in & ~s_prev;

  assign s_p   = rank_of(s_irr & ~slv_mask, s_rot);
  assign s_cur = rank_of(s_isr, s_rot);
  assign s_int = s_p < s_cur;
  assign s_ln  = s_p[2:0] + s_rot;

  assign m_req = (m_irr & ~CAS_BIT) | (s_int ? CAS_BIT : 8'h00);
  assign m_p   = rank_of(m_req & ~mst_mask, m_rot);
  assign m_cur = rank_of(m_isr, m_rot);
  assign cpu_int = m_p < m_cur;
  assign m_ln  = m_p[2:0] + m_rot;

  assign m_take = ack && cpu_int;
  assign s_take = m_take && (m_ln == CAS_IDX) && s_int;
  assign m_bit  = 8'(1) << m_ln;
  assign s_bit  = 8'(1) << s_ln;
  assign m_clr  = m_take ? (m_bit & ~m_trg) : 8'h00;
  assign s_clr  = s_take ? (s_bit & ~s_trg) : 8'h00;

  assign trig_rdata = trig_sel ? (s_trg & SLV_KEEP) : (m_trg & MST_KEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_irr <= '0; m_isr <= '0; m_prev <= '0; m_rot <= '0;
      s_irr <= '0; s_isr <= '0; s_prev <= '0; s_rot <= '0;
      m_trg <= CAS_BIT; s_trg <= '0;
      vec <= '0; vec_vld <= 1'b0;
    end else begin
      m_prev <= m_in;
      s_prev <= s_in;
      m_irr  <= (m_trg & m_in) | (~m_trg & ((m_irr & ~m_clr) | m_rise));
      s_irr  <= (s_trg & s_in) | (~s_trg & ((s_irr & ~s_clr) | s_rise));
      if (m_take) begin
        if (!aeoi) m_isr <= m_isr | m_bit;
        else if (rot_aeoi) m_rot <= m_ln + 3'd1;
      end
      if (s_take) begin
        if (!aeoi) s_isr <= s_isr | s_bit;
        else if (rot_aeoi) s_rot <= s_ln + 3'd1;
      end
      if (trig_we) begin
        if (trig_sel) s_trg <= trig_wdata & SLV_KEEP;
        else          m_trg <= (trig_wdata & MST_KEEP) | CAS_BIT;
      end
      vec_vld <= m_take;
      if (m_take) vec <= s_take ? {slv_base, s_ln} : {mst_base, m_ln};
    end
  end

  // R10
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !cpu_int) |=> !vec_vld);
  // R3
  isr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && cpu_int && !aeoi) |=> m_isr[$past(m_ln)]);
  // R4
  rot_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && cpu_int && aeoi && rot_aeoi) |=> (m_rot == $past(m_ln) + 3'd1));
  // R5
  cascade_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && cpu_int && m_ln == CAS_IDX) |=> (vec_vld && vec[7:3] == $past(slv_base)));
  // R2
  edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && cpu_int && m_ln != CAS_IDX && !m_trg[m_ln] && !m_rise[m_ln])
      |=> !m_irr[$past(m_ln)]);
endmodule

// File: tb/tb_casc_irq_ack.sv
`timescale 1ns/1ps
module tb_casc_irq_ack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic        ack = 1'b0;
  logic        trig_we = 1'b0;
  logic        trig_sel = 1'b0;
  logic [7:0]  trig_wdata = '0;
  logic [7:0]  trig_rdata;
  logic [4:0]  mst_base = 5'h04;
  logic [4:0]  slv_base = 5'h0E;
  logic [7:0]  mst_mask = '0;
  logic [7:0]  slv_mask = '0;
  logic        aeoi = 1'b0;
  logic        rot_aeoi = 1'b0;
  logic        cpu_int;
  logic [7:0]  vec;
  logic        vec_vld;

  int nchk = 0;
  int nbad = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic       ack_q = 1'b0;

  casc_irq_ack dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) ack_q <= ack;

  always @(negedge clk) begin
    if (ack_q && exp_q.size() > 0) begin
      logic [8:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {vec_vld, e[8] ? vec : 8'h00}, e);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack(input string tag, input logic v, input logic [7:0] e);
    @(negedge clk);
    ack = 1'b1;
    exp_q.push_back({v, v ? e : 8'h00});
    tag_q.push_back(tag);
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic wr_trig(input logic sel, input logic [7:0] d);
    @(negedge clk);
    trig_sel = sel; trig_wdata = d; trig_we = 1'b1;
    @(negedge clk);
    trig_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; irq_in = '0; aeoi = 1'b0; rot_aeoi = 1'b0;
    mst_mask = '0; slv_mask = '0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    do_reset();
    // R9 reset state
    chk("R9 cpu_int", {8'h0, cpu_int}, 9'h0);
    chk("R9 vec_vld", {8'h0, vec_vld}, 9'h0);
    trig_sel = 1'b0; #1;
    chk("R9 master trig", {1'b0, trig_rdata}, 9'h000);
    trig_sel = 1'b1; #1;
    chk("R9 slave trig", {1'b0, trig_rdata}, 9'h000);

    // R7 / R8 trigger masks
    wr_trig(1'b0, 8'hFF);
    trig_sel = 1'b0; #1;
    chk("R7 master read", {1'b0, trig_rdata}, 9'h0F8);
    wr_trig(1'b1, 8'hFF);
    trig_sel = 1'b1; #1;
    chk("R8 slave read", {1'b0, trig_rdata}, 9'h0DE);
    wr_trig(1'b0, 8'h00);
    wr_trig(1'b1, 8'h00);

    // R6 edge line 5, R2 edge clear, R3 in-service blocking
    irq_in[5] = 1'b1;
    step(1);
    chk("R6 int raised", {8'h0, cpu_int}, 9'h1);
    do_ack("R6 vector line5", 1'b1, 8'h25);
    chk("R2 edge cleared", {8'h0, cpu_int}, 9'h0);
    irq_in[6] = 1'b1;
    step(1);
    chk("R3 lower blocked", {8'h0, cpu_int}, 9'h0);
    irq_in[4] = 1'b1;
    step(1);
    chk("R3 higher passes", {8'h0, cpu_int}, 9'h1);

    // R10 ack with nothing pending
    do_reset();
    do_ack("R10 idle ack", 1'b0, 8'h00);
    chk("R10 still idle", {8'h0, cpu_int}, 9'h0);

    // R1 external line 2 ignored
    irq_in[2] = 1'b1;
    step(2);
    chk("R1 line2 ignored", {8'h0, cpu_int}, 9'h0);
    do_ack("R1 ack none", 1'b0, 8'h00);
    irq_in[2] = 1'b0;

    // R5 cascade to slave line 4 (irq 12)
    irq_in[12] = 1'b1;
    step(1);
    chk("R1 slave drives master2", {8'h0, cpu_int}, 9'h1);
    do_ack("R5 cascade vec", 1'b1, 8'h74);
    chk("R5 both in service", {8'h0, cpu_int}, 9'h0);

    // R2 level line on slave 1 (irq 9) with auto-EOI
    do_reset();
    aeoi = 1'b1;
    wr_trig(1'b1, 8'h02);
    irq_in[9] = 1'b1;
    step(1);
    do_ack("R2 level first", 1'b1, 8'h71);
    chk("R2 level kept", {8'h0, cpu_int}, 9'h1);
    do_ack("R2 level again", 1'b1, 8'h71);
    irq_in[9] = 1'b0;
    step(1);
    chk("R1 slave fall clears", {8'h0, cpu_int}, 9'h0);

    // R4 rotate on auto-EOI
    do_reset();
    aeoi = 1'b1; rot_aeoi = 1'b1;
    irq_in[3] = 1'b1; irq_in[6] = 1'b1;
    step(1);
    do_ack("R4 first line3", 1'b1, 8'h23);
    irq_in[1] = 1'b1;
    step(1);
    do_ack("R4 rotated line6", 1'b1, 8'h26);
    do_ack("R4 then line1", 1'b1, 8'h21);
    chk("R4 drained", {8'h0, cpu_int}, 9'h0);

    // R11 mask
    do_reset();
    mst_mask = 8'h20;
    irq_in[5] = 1'b1;
    step(2);
    chk("R11 masked", {8'h0, cpu_int}, 9'h0);
    mst_mask = 8'h00;
    step(1);
    chk("R11 unmasked", {8'h0, cpu_int}, 9'h1);

    step(2);
    if (exp_q.size() != 0) begin
      nbad++;
      $display("FAIL R6 unconsumed expectations actual=%0d expected=0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule